// File: doc/BRIEF.md
# Accumulator Register-Operation Executor

This block carries out the register-operation class of instructions for a 16-bit accumulator machine. It holds the accumulator (AC) and its one-bit extension flip-flop (E). In the execute phase it modifies them, tells the program counter logic to step once more when a skip condition is met, and tells the run control to stop when a halt is requested. The surrounding sequencer presents the decoded opcode line for pattern 111, the indirect bit and the T3 timing phase. The block acts only when all three agree: opcode line high, indirect bit low, T3 high.

Each of the twelve low instruction bits selects one operation, so a single instruction word can request several of them at once. Operations that change AC or E are applied in a fixed order, each stage taking the result of the one before. Skip conditions always look at the values AC and E held before the instruction. The rest of the datapath can write AC and E through a load port between instructions.

Top module: `regref_exec`

## Requirements
- R1: The block is enabled only when `dec_op7`=1, `ind_bit`=0 and `phase_t3`=1 in the same cycle. When it is not enabled, `pc_skip`, `halt_clr` and `sc_clr` stay 0, and AC and E keep their value unless the load port writes them.
- R2: `sc_clr` is 1 during every enabled cycle, whatever the instruction bits are.
- R3: Instruction bit 11 clears AC; the full word for this alone is 0x7800. Bit 10 clears E.
- R4: Bit 9 complements AC. Bit 8 complements E.
- R5: Bit 7 rotates {E,AC} right. The new E is the old AC[0], and the new AC[15] is the old E.
- R6: Bit 6 rotates {E,AC} left. The new E is the old AC[15], and the new AC[0] is the old E.
- R7: Bit 5 increments AC modulo 2^16 and leaves E unchanged (0xFFFF becomes 0x0000).
- R8: Bit 4 skips if AC[15]=0. Bit 3 skips if AC[15]=1. Bit 2 skips if AC is all zeros. Bit 1 skips if E=0. `pc_skip` is 1 during the enabled cycle when any selected condition holds, judged on the AC and E values from before the instruction.
- R9: Bit 0 drives `halt_clr` to 1 during the enabled cycle and does not change AC or E.
- R10: AC and E change at the clock edge that ends the enabled cycle. When several modifying bits are set, they apply in the order bit 11, 10, 9, 8, 7, 6, 5, each on the previous result (bits 11 and 9 together give AC=0xFFFF).
- R11: With `ld_en`=1 in a cycle that is not enabled, AC takes `ld_ac` and E takes `ld_e` at the next edge. In an enabled cycle the load port is ignored.
- R12: After reset, AC=0x0000 and E=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_op7 | input | 1 | Opcode decoder line for opcode 111 |
| ind_bit | input | 1 | Indirect bit of the current instruction |
| phase_t3 | input | 1 | Timing phase T3 active |
| ir_low | input | 12 | Instruction bits 11..0, one bit per operation |
| ld_en | input | 1 | Load strobe from the rest of the datapath |
| ld_ac | input | 16 | Value to load into AC |
| ld_e | input | 1 | Value to load into E |
| ac_q | output | 16 | Accumulator |
| e_q | output | 1 | Extension flip-flop |
| pc_skip | output | 1 | Extra program counter increment request |
| halt_clr | output | 1 | Clear request for the start-stop flip-flop |
| sc_clr | output | 1 | Sequence counter clear |

## Verification
Two functions can fall in the same enabled cycle: a skip test and a modification of the register that the test reads. An instruction word can also both clear AC and test AC for zero. The bench provokes this with such combined words, for example clear plus zero-skip applied once to a nonzero AC and once to a zero AC. It judges `pc_skip` against the AC value from before the instruction, and it judges the final AC against the ordered chain of R10. It also drives the load port in the same cycle as an enabled instruction and checks that the instruction's result, not the loaded value, appears on `ac_q`.

// File: rtl/regref_pkg.sv
package regref_pkg;

    localparam int OP_BITS  = 12;
    localparam int MOD_OPS  = 7;
    localparam int SKIP_OPS = 4;

    // Bit positions inside the instruction's low field
    localparam int BIT_CLR_AC = 11;
    localparam int BIT_CLR_E  = 10;
    localparam int BIT_CPL_AC = 9;
    localparam int BIT_CPL_E  = 8;
    localparam int BIT_ROT_R  = 7;
    localparam int BIT_ROT_L  = 6;
    localparam int BIT_INC_AC = 5;
    localparam int BIT_SK_POS = 4;
    localparam int BIT_SK_NEG = 3;
    localparam int BIT_SK_ZER = 2;
    localparam int BIT_SK_EZ  = 1;
    localparam int BIT_HALT   = 0;

    typedef struct packed {
        logic clr_ac;
        logic clr_e;
        logic cpl_ac;
        logic cpl_e;
        logic rot_r;
        logic rot_l;
        logic inc_ac;
    } mod_sel_t;

    typedef struct packed {
        logic sk_pos;
        logic sk_neg;
        logic sk_zer;
        logic sk_ez;
    } skip_sel_t;

endpackage

// File: rtl/regref_decode.sv
module regref_decode
    import regref_pkg::*;
(
    input  logic               dec_op7,
    input  logic               ind_bit,
    input  logic               phase_t3,
    input  logic [OP_BITS-1:0] ir_low,
    output logic               exec_en,
    output mod_sel_t           mod_sel,
    output skip_sel_t          skip_sel,
    output logic               halt_req
);

    logic [OP_BITS-1:0] gated;

    always_comb begin
        exec_en = dec_op7 && !ind_bit && phase_t3;
    end

    genvar gi;
    generate
        for (gi = 0; gi < OP_BITS; gi++) begin : g_gate
            assign gated[gi] = exec_en & ir_low[gi];
        end
    endgenerate

    always_comb begin
        mod_sel.clr_ac  = gated[BIT_CLR_AC];
        mod_sel.clr_e   = gated[BIT_CLR_E];
        mod_sel.cpl_ac  = gated[BIT_CPL_AC];
        mod_sel.cpl_e   = gated[BIT_CPL_E];
        mod_sel.rot_r   = gated[BIT_ROT_R];
        mod_sel.rot_l   = gated[BIT_ROT_L];
        mod_sel.inc_ac  = gated[BIT_INC_AC];
        skip_sel.sk_pos = gated[BIT_SK_POS];
        skip_sel.sk_neg = gated[BIT_SK_NEG];
        skip_sel.sk_zer = gated[BIT_SK_ZER];
        skip_sel.sk_ez  = gated[BIT_SK_EZ];
        halt_req        = gated[BIT_HALT];
    end

endmodule

// File: rtl/regref_alu.sv
module regref_alu
    import regref_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic             ext_in,
    input  mod_sel_t         mod_sel,
    output logic [ACC_W-1:0] acc_out,
    output logic             ext_out
);

    localparam int MSB = ACC_W - 1;

    // Stage values: index 0 is the input, each later stage one operation on
    logic [ACC_W-1:0] acc_st [MOD_OPS+1];
    logic             ext_st [MOD_OPS+1];

    always_comb begin
        acc_st[0] = acc_in;
        ext_st[0] = ext_in;

        acc_st[1] = mod_sel.clr_ac ? '0 : acc_st[0];
        ext_st[1] = ext_st[0];

        acc_st[2] = acc_st[1];
        ext_st[2] = mod_sel.clr_e ? 1'b0 : ext_st[1];

        acc_st[3] = mod_sel.cpl_ac ? ~acc_st[2] : acc_st[2];
        ext_st[3] = ext_st[2];

        acc_st[4] = acc_st[3];
        ext_st[4] = mod_sel.cpl_e ? ~ext_st[3] : ext_st[3];

        if (mod_sel.rot_r) begin
            acc_st[5] = {ext_st[4], acc_st[4][MSB:1]};
            ext_st[5] = acc_st[4][0];
        end else begin
            acc_st[5] = acc_st[4];
            ext_st[5] = ext_st[4];
        end

        if (mod_sel.rot_l) begin
            acc_st[6] = {acc_st[5][MSB-1:0], ext_st[5]};
            ext_st[6] = acc_st[5][MSB];
        end else begin
            acc_st[6] = acc_st[5];
            ext_st[6] = ext_st[5];
        end

        acc_st[7] = mod_sel.inc_ac ? acc_st[6] + 1'b1 : acc_st[6];
        ext_st[7] = ext_st[6];

        acc_out = acc_st[MOD_OPS];
        ext_out = ext_st[MOD_OPS];
    end

endmodule

// File: rtl/regref_cond.sv
module regref_cond
    import regref_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic             ext_in,
    input  skip_sel_t        skip_sel,
    output logic             skip_out
);

    logic acc_neg;
    logic acc_zero;
    logic [SKIP_OPS-1:0] hits;

    always_comb begin
        acc_neg  = acc_in[ACC_W-1];
        acc_zero = (acc_in == '0);
        hits[3]  = skip_sel.sk_pos && !acc_neg;
        hits[2]  = skip_sel.sk_neg && acc_neg;
        hits[1]  = skip_sel.sk_zer && acc_zero;
        hits[0]  = skip_sel.sk_ez  && !ext_in;
        skip_out = |hits;
    end

endmodule

// File: rtl/regref_exec.sv
module regref_exec
    import regref_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_op7,
    input  logic               ind_bit,
    input  logic               phase_t3,
    input  logic [OP_BITS-1:0] ir_low,
    input  logic               ld_en,
    input  logic [ACC_W-1:0]   ld_ac,
    input  logic               ld_e,
    output logic [ACC_W-1:0]   ac_q,
    output logic               e_q,
    output logic               pc_skip,
    output logic               halt_clr,
    output logic               sc_clr
);

    typedef struct packed {
        logic [ACC_W-1:0] ac;
        logic             e;
    } regs_t;

    regs_t      regs_d, regs_q;
    logic       exec_en;
    mod_sel_t   mod_sel;
    skip_sel_t  skip_sel;
    logic       halt_req;
    logic [ACC_W-1:0] alu_ac;
    logic             alu_e;
    logic             skip_hit;

    regref_decode u_decode (
        .dec_op7  (dec_op7),
        .ind_bit  (ind_bit),
        .phase_t3 (phase_t3),
        .ir_low   (ir_low),
        .exec_en  (exec_en),
        .mod_sel  (mod_sel),
        .skip_sel (skip_sel),
        .halt_req (halt_req)
    );

    regref_alu #(.ACC_W(ACC_W)) u_alu (
        .acc_in  (regs_q.ac),
        .ext_in  (regs_q.e),
        .mod_sel (mod_sel),
        .acc_out (alu_ac),
        .ext_out (alu_e)
    );

    regref_cond #(.ACC_W(ACC_W)) u_cond (
        .acc_in   (regs_q.ac),
        .ext_in   (regs_q.e),
        .skip_sel (skip_sel),
        .skip_out (skip_hit)
    );

    always_comb begin
        regs_d = regs_q;
        if (exec_en) begin
            regs_d.ac = alu_ac;
            regs_d.e  = alu_e;
        end else if (ld_en) begin
            regs_d.ac = ld_ac;
            regs_d.e  = ld_e;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        ac_q     = regs_q.ac;
        e_q      = regs_q.e;
        pc_skip  = skip_hit;
        halt_clr = halt_req;
        sc_clr   = exec_en;
    end

    // R8
    skip_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_skip |-> sc_clr);

    // R9
    halt_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_clr |-> (sc_clr && !pc_skip) || (sc_clr && pc_skip));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sc_clr && !ld_en) |=> $stable(ac_q) && $stable(e_q));

    // R5
    rot_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clr && ir_low == 12'h080) |=> (e_q == $past(ac_q[0])) &&
                                          (ac_q[ACC_W-1] == $past(e_q)));

    // R6
    rot_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clr && ir_low == 12'h040) |=> (e_q == $past(ac_q[ACC_W-1])) &&
                                          (ac_q[0] == $past(e_q)));

    // R7
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clr && ir_low == 12'h020) |=> (ac_q == $past(ac_q) + 1'b1) &&
                                          $stable(e_q));

    // R8
    zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clr && ir_low[BIT_SK_ZER] && ac_q == '0) |-> pc_skip);

    // R11
    load_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sc_clr && ld_en) |=> (ac_q == $past(ld_ac)) && (e_q == $past(ld_e)));

endmodule

// File: tb/sim_regref_exec.sv
module sim_regref_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_op7 = 1'b0;
    logic        ind_bit = 1'b0;
    logic        phase_t3 = 1'b0;
    logic [11:0] ir_low = '0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_ac = '0;
    logic        ld_e = 1'b0;
    logic [15:0] ac_q;
    logic        e_q;
    logic        pc_skip;
    logic        halt_clr;
    logic        sc_clr;

    int checks = 0;
    int failures = 0;
    logic s_skip, s_halt, s_sc;

    always #4 clk = ~clk;

    regref_exec u0 (
        .clk(clk), .rst_n(rst_n), .dec_op7(dec_op7), .ind_bit(ind_bit),
        .phase_t3(phase_t3), .ir_low(ir_low), .ld_en(ld_en), .ld_ac(ld_ac),
        .ld_e(ld_e), .ac_q(ac_q), .e_q(e_q), .pc_skip(pc_skip),
        .halt_clr(halt_clr), .sc_clr(sc_clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] v, input logic ev);
        @(negedge clk);
        ld_en = 1'b1; ld_ac = v; ld_e = ev;
        @(posedge clk);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Drive one instruction; strobes sampled mid-cycle, registers after the edge
    task automatic run(input logic d7, input logic ib, input logic t3, input logic [11:0] ir);
        @(negedge clk);
        dec_op7 = d7; ind_bit = ib; phase_t3 = t3; ir_low = ir;
        #1;
        s_skip = pc_skip; s_halt = halt_clr; s_sc = sc_clr;
        @(posedge clk);
        @(negedge clk);
        dec_op7 = 1'b0; ind_bit = 1'b0; phase_t3 = 1'b0; ir_low = '0;
    endtask

    task automatic t_reset();
        chk("R12 ac", ac_q, 16'h0000);
        chk("R12 e", e_q, 1'b0);
    endtask

    task automatic t_enable();
        load(16'h1234, 1'b1);
        chk("R11 load ac", ac_q, 16'h1234);
        run(1'b1, 1'b1, 1'b1, 12'h800);
        chk("R1 indirect ac", ac_q, 16'h1234);
        chk("R1 indirect sc", s_sc, 1'b0);
        run(1'b1, 1'b0, 1'b0, 12'h804);
        chk("R1 no t3 ac", ac_q, 16'h1234);
        chk("R1 no t3 sc", s_sc, 1'b0);
        run(1'b0, 1'b0, 1'b1, 12'h801);
        chk("R1 no d7 halt", s_halt, 1'b0);
        chk("R1 no d7 e", e_q, 1'b1);
    endtask

    task automatic t_clear_cpl();
        run(1'b1, 1'b0, 1'b1, 12'h800);
        chk("R3 clear ac", ac_q, 16'h0000);
        chk("R2 sc clear", s_sc, 1'b1);
        run(1'b1, 1'b0, 1'b1, 12'h400);
        chk("R3 clear e", e_q, 1'b0);
        load(16'h00FF, 1'b0);
        run(1'b1, 1'b0, 1'b1, 12'h200);
        chk("R4 cpl ac", ac_q, 16'hFF00);
        run(1'b1, 1'b0, 1'b1, 12'h100);
        chk("R4 cpl e", e_q, 1'b1);
    endtask

    task automatic t_rotate();
        load(16'h8001, 1'b0);
        run(1'b1, 1'b0, 1'b1, 12'h080);
        chk("R5 rot right ac", ac_q, 16'h4000);
        chk("R5 rot right e", e_q, 1'b1);
        load(16'h8001, 1'b1);
        run(1'b1, 1'b0, 1'b1, 12'h040);
        chk("R6 rot left ac", ac_q, 16'h0003);
        chk("R6 rot left e", e_q, 1'b1);
    endtask

    task automatic t_incr();
        load(16'hFFFF, 1'b1);
        run(1'b1, 1'b0, 1'b1, 12'h020);
        chk("R7 inc wrap ac", ac_q, 16'h0000);
        chk("R7 inc keeps e", e_q, 1'b1);
    endtask

    task automatic t_skips();
        load(16'h8000, 1'b0);
        run(1'b1, 1'b0, 1'b1, 12'h010);
        chk("R8 pos on negative", s_skip, 1'b0);
        run(1'b1, 1'b0, 1'b1, 12'h008);
        chk("R8 neg on negative", s_skip, 1'b1);
        run(1'b1, 1'b0, 1'b1, 12'h004);
        chk("R8 zero on nonzero", s_skip, 1'b0);
        run(1'b1, 1'b0, 1'b1, 12'h002);
        chk("R8 e zero", s_skip, 1'b1);
        load(16'h0000, 1'b1);
        run(1'b1, 1'b0, 1'b1, 12'h012);
        chk("R8 pos on zero", s_skip, 1'b1);
        run(1'b1, 1'b0, 1'b1, 12'h002);
        chk("R8 e set", s_skip, 1'b0);
    endtask

    task automatic t_halt();
        load(16'h0055, 1'b1);
        run(1'b1, 1'b0, 1'b1, 12'h001);
        chk("R9 halt strobe", s_halt, 1'b1);
        chk("R9 halt ac", ac_q, 16'h0055);
        chk("R9 halt e", e_q, 1'b1);
    endtask

    task automatic t_combined();
        load(16'h0005, 1'b0);
        run(1'b1, 1'b0, 1'b1, 12'h804);
        chk("R8 clear+zero old nonzero", s_skip, 1'b0);
        chk("R10 clear ac", ac_q, 16'h0000);
        run(1'b1, 1'b0, 1'b1, 12'h804);
        chk("R8 clear+zero old zero", s_skip, 1'b1);
        run(1'b1, 1'b0, 1'b1, 12'hA00);
        chk("R10 clear then cpl", ac_q, 16'hFFFF);
        run(1'b1, 1'b0, 1'b1, 12'h500);
        chk("R10 clear e then cpl e", e_q, 1'b1);
        run(1'b1, 1'b0, 1'b1, 12'h820);
        chk("R10 clear then inc", ac_q, 16'h0001);
    endtask

    task automatic t_load_ignored();
        load(16'h00FF, 1'b0);
        @(negedge clk);
        dec_op7 = 1'b1; phase_t3 = 1'b1; ir_low = 12'h200;
        ld_en = 1'b1; ld_ac = 16'h1234; ld_e = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dec_op7 = 1'b0; phase_t3 = 1'b0; ir_low = '0; ld_en = 1'b0;
        chk("R11 load ignored ac", ac_q, 16'hFF00);
        chk("R11 load ignored e", e_q, 1'b0);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_enable();
        t_clear_cpl();
        t_rotate();
        t_incr();
        t_skips();
        t_halt();
        t_combined();
        t_load_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule